// File: doc/BRIEF.md
# Metering Package Sequencer

This block is the transmit end of a link that carries measurement results from a metering signal processor to a host controller. On a fixed period it sends a package of sixteen bytes over a byte-wide bus. Each byte is marked by a one-cycle strobe. A data-ready level frames the whole package so that the host can take it as an interrupt. Normal packages carry an index that runs 0 to 5 and then wraps. Every package opens with a fixed sync byte and a code byte. A byte with the mode pins and a byte with the status bus follow. Twelve payload bytes from a register input close the package.

The code byte also carries two reserved values. Before any other decision, a power-fail input is checked at each package boundary. If it is set, the sequencer sends an announce package with code 7. It then sends the two billing packages, 3 and 4, back to back, and the normal cycle starts again at package 0. If power is good and the calibration-request input is set, a package with code 6 goes out instead. The sequencer then stays silent until the host signals calibration done. After that, package 0 starts at once and the period timer restarts.

Top module: `meter_pkg_tx`

## Requirements
- R1: While reset is asserted, data_ready and byte_strobe are low and byte_data is zero.
- R2: Each package holds data_ready high for exactly 210 consecutive cycles and gives exactly 16 byte strobes. The first strobe comes 11 cycles after data_ready rises.
- R3: The spacing between strobes depends on the index of the earlier byte: 12 cycles after an even-indexed byte and 13 after an odd-indexed one. data_ready drops 12 cycles after the strobe of byte 15.
- R4: Byte 0 is always 0x80. Byte 1 holds the package code in bits 2..0 and has bits 7..3 at zero.
- R5: Byte 2 holds mode_pins in its low MODE_W bits, with the other bits at zero. Byte 3 is the value of status_bus at its strobe.
- R6: For codes 0 to 5, byte k (4 to 15) is payload_in[8*(k-4) +: 8]. For codes 6 and 7, bytes 4 to 15 are zero. byte_data is zero in every cycle without a strobe.
- R7: When no reserved condition is present, package starts are PERIOD cycles apart and the codes run 0,1,2,3,4,5,0,...
- R8: If pfail_in is high at a boundary, a code-7 package is sent. Package 3 and then package 4 follow. Each of them rises 211 cycles after the previous rise, with one low cycle in between. The next boundary package has code 0.
- R9: If cal_req_in is high at a boundary and pfail_in is low, a code-6 package is sent. After it, data_ready stays low until cal_done_in is seen. Package 0 rises one cycle after the cycle in which cal_done_in is high. The next package follows PERIOD cycles after that.
- R10: When pfail_in and cal_req_in are both high at a boundary, the power-fail sequence wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail_in | input | 1 | Power-failure flag, sampled at package boundaries |
| cal_req_in | input | 1 | Calibration request, sampled at package boundaries |
| cal_done_in | input | 1 | Host has supplied calibration; ends the wait |
| mode_pins | input | MODE_W | Mode strap value reported in byte 2 |
| status_bus | input | 8 | External status value reported in byte 3 |
| payload_in | input | 96 | Twelve payload bytes, byte 4 in the low bits |
| data_ready | output | 1 | High for the whole duration of a package |
| byte_strobe | output | 1 | One-cycle strobe marking a valid byte |
| byte_data | output | 8 | Byte value, zero outside strobes |

## Verification
All outputs are decoded straight from registered state. The first cycle in which data_ready is seen high is therefore taken as offset 0, and every other result is due at a fixed offset from it. The strobes fall at offsets 11, 23, 36 and so on up to 198, and data_ready is low again at offset 210. A chained billing package rises at offset 211. The package after a calibration-done pulse rises one cycle after the pulse. The bench samples on falling edges and counts falling edges from each rise. It compares each strobe time and each byte against a schedule and byte values that it builds from these offsets and from its own vector table. It then compares the distance between rises with PERIOD, with 211, or with the cycle of the done pulse, depending on the case.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
    localparam int FRAME_BYTES = 16;
    localparam int HDR_BYTES   = 4;
    localparam int NUM_PKG     = 6;
    localparam logic [7:0] SYNC_HI     = 8'h80;
    localparam logic [2:0] CODE_CAL    = 3'd6;
    localparam logic [2:0] CODE_PFAIL  = 3'd7;
    localparam logic [2:0] BILL_FIRST  = 3'd3;
    localparam logic [2:0] BILL_SECOND = 3'd4;

    typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_XFER} phase_e;
    typedef enum logic {CM_RUN, CM_CALWAIT} ctrl_mode_e;
endpackage

// File: rtl/mpt_period_timer.sv
module mpt_period_timer #(
    parameter int PERIOD = 109227,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic boundary
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign boundary = (cnt_q == CW'(PERIOD - 1));

    always_comb begin
        if (restart || boundary) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: a boundary is a single-cycle event
    a_r7_single_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !boundary);
endmodule

// File: rtl/mpt_frame_engine.sv
module mpt_frame_engine
    import mpt_pkg::*;
#(
    parameter int LEAD_CYC = 11,
    parameter int GAP_EVEN = 12,
    parameter int GAP_ODD  = 13,
    parameter int TAIL_CYC = 12,
    localparam int IDX_W  = $clog2(FRAME_BYTES),
    localparam int M1     = (LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC,
    localparam int M2     = (GAP_EVEN > GAP_ODD) ? GAP_EVEN : GAP_ODD,
    localparam int TMAX   = (M1 > M2) ? M1 : M2,
    localparam int TICK_W = $clog2(TMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic             strobe,
    output logic             last_cycle,
    output logic [IDX_W-1:0] byte_idx
);
    typedef struct packed {
        phase_e            phase;
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
    } eng_s;

    eng_s q, d;
    logic [TICK_W-1:0] limit;

    always_comb begin
        d          = q;
        last_cycle = 1'b0;
        if (q.idx == IDX_W'(FRAME_BYTES - 1)) limit = TICK_W'(TAIL_CYC - 1);
        else if (q.idx[0])                    limit = TICK_W'(GAP_ODD - 1);
        else                                  limit = TICK_W'(GAP_EVEN - 1);
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_LEAD;
                    d.tick  = '0;
                    d.idx   = '0;
                end
            end
            PH_LEAD: begin
                if (q.tick == TICK_W'(LEAD_CYC - 1)) begin
                    d.phase = PH_XFER;
                    d.tick  = '0;
                    d.idx   = '0;
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            PH_XFER: begin
                if (q.tick == limit) begin
                    d.tick = '0;
                    if (q.idx == IDX_W'(FRAME_BYTES - 1)) begin
                        d.phase    = PH_IDLE;
                        last_cycle = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, tick: '0, idx: '0};
        else        q <= d;
    end

    assign active   = (q.phase != PH_IDLE);
    assign strobe   = (q.phase == PH_XFER) && (q.tick == '0);
    assign byte_idx = q.idx;

    // R2: strobes never come in adjacent cycles
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R2: a package opens with a lead-in, not with a byte
    a_r2_lead_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !strobe ##1 active);
endmodule

// File: rtl/mpt_seq_ctrl.sv
module mpt_seq_ctrl
    import mpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       pfail,
    input  logic       cal_req,
    input  logic       cal_done,
    input  logic       eng_active,
    input  logic       eng_last,
    output logic       start,
    output logic       restart,
    output logic [2:0] code
);
    typedef struct packed {
        ctrl_mode_e mode;
        logic [2:0] code;
        logic [2:0] next_pkg;
        logic [1:0] chain;
        logic       cal_pend;
    } ctrl_s;

    ctrl_s q, d;

    always_comb begin
        d       = q;
        start   = 1'b0;
        restart = 1'b0;
        if (q.mode == CM_CALWAIT) begin
            if (cal_done) begin
                start      = 1'b1;
                restart    = 1'b1;
                d.mode     = CM_RUN;
                d.code     = 3'd0;
                d.next_pkg = 3'd1;
            end
        end else if (!eng_active) begin
            if (q.chain != 2'd0) begin
                start   = 1'b1;
                d.code  = (q.chain == 2'd2) ? BILL_FIRST : BILL_SECOND;
                d.chain = q.chain - 1'b1;
            end else if (boundary) begin
                start = 1'b1;
                if (pfail) begin
                    d.code     = CODE_PFAIL;
                    d.chain    = 2'd2;
                    d.next_pkg = 3'd0;
                end else if (cal_req) begin
                    d.code     = CODE_CAL;
                    d.cal_pend = 1'b1;
                end else begin
                    d.code     = q.next_pkg;
                    d.next_pkg = (q.next_pkg == 3'(NUM_PKG - 1)) ? 3'd0 : q.next_pkg + 1'b1;
                end
            end
        end
        if (eng_last && q.cal_pend) begin
            d.mode     = CM_CALWAIT;
            d.cal_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: CM_RUN, code: 3'd0, next_pkg: 3'd0, chain: 2'd0, cal_pend: 1'b0};
        else        q <= d;
    end

    assign code = q.code;

    // R9: nothing is sent while waiting for calibration
    a_r9_silent_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == CM_CALWAIT) |-> !eng_active);
    // R10: power failure outranks the calibration request
    a_r10_pfail_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == CM_RUN && !eng_active && q.chain == 2'd0 && boundary && pfail)
        |=> (q.code == CODE_PFAIL));
    // R8: a billing package restarts after exactly one low cycle
    a_r8_chain_back: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_last && q.chain != 2'd0) |-> ##2 eng_active);
endmodule

// File: rtl/mpt_byte_mux.sv
module mpt_byte_mux
    import mpt_pkg::*;
#(
    parameter int MODE_W = 3,
    localparam int IDX_W = $clog2(FRAME_BYTES),
    localparam int PAY_W = (FRAME_BYTES - HDR_BYTES) * 8
) (
    input  logic              valid,
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        code,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [7:0]        status,
    input  logic [PAY_W-1:0]  payload,
    output logic [7:0]        data
);
    logic no_payload;
    assign no_payload = (code == CODE_CAL) || (code == CODE_PFAIL);

    always_comb begin
        data = 8'h00;
        if (valid) begin
            case (idx)
                IDX_W'(0): data = SYNC_HI;
                IDX_W'(1): data = {5'b00000, code};
                IDX_W'(2): data = 8'(mode_pins);
                IDX_W'(3): data = status;
                default: begin
                    for (int k = HDR_BYTES; k < FRAME_BYTES; k++) begin
                        if (idx == IDX_W'(k) && !no_payload)
                            data = payload[(k - HDR_BYTES) * 8 +: 8];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/meter_pkg_tx.sv
module meter_pkg_tx
    import mpt_pkg::*;
#(
    parameter int PERIOD = 109227,
    parameter int MODE_W = 3,
    localparam int PAY_W = (FRAME_BYTES - HDR_BYTES) * 8,
    localparam int IDX_W = $clog2(FRAME_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail_in,
    input  logic              cal_req_in,
    input  logic              cal_done_in,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [7:0]        status_bus,
    input  logic [PAY_W-1:0]  payload_in,
    output logic              data_ready,
    output logic              byte_strobe,
    output logic [7:0]        byte_data
);
    logic             boundary, restart, start;
    logic             eng_active, eng_last;
    logic [IDX_W-1:0] byte_idx;
    logic [2:0]       code;

    mpt_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .boundary(boundary)
    );

    mpt_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .pfail(pfail_in), .cal_req(cal_req_in), .cal_done(cal_done_in),
        .eng_active(eng_active), .eng_last(eng_last),
        .start(start), .restart(restart), .code(code)
    );

    mpt_frame_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .active(eng_active),
        .strobe(byte_strobe), .last_cycle(eng_last), .byte_idx(byte_idx)
    );

    mpt_byte_mux #(.MODE_W(MODE_W)) u_mux (
        .valid(byte_strobe), .idx(byte_idx), .code(code),
        .mode_pins(mode_pins), .status(status_bus),
        .payload(payload_in), .data(byte_data)
    );

    assign data_ready = eng_active;

    // R6: the byte bus is quiet between strobes
    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_strobe |-> (byte_data == 8'h00));
    // R2: bytes only appear inside the data-ready window
    a_r2_strobe_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> data_ready);
endmodule

// File: tb/meter_pkg_tx_test.sv
module meter_pkg_tx_test;
    localparam int P  = 300;
    localparam int MW = 3;
    localparam int PW = 96;
    localparam int NV = 15;

    typedef struct packed {
        logic       pf;
        logic       cr;
        logic       done;
        logic [2:0] code;
        logic [1:0] gap;   // 0 skip, 1 PERIOD, 2 chained 211, 3 one after done pulse
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 3'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 3'd1, 2'd1},
        '{1'b1, 1'b1, 1'b0, 3'd7, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd3, 2'd2},
        '{1'b0, 1'b0, 1'b0, 3'd4, 2'd2},
        '{1'b0, 1'b0, 1'b0, 3'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 3'd1, 2'd1},
        '{1'b0, 1'b1, 1'b1, 3'd6, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd0, 2'd3},
        '{1'b0, 1'b0, 1'b0, 3'd1, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd2, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd3, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd4, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd5, 2'd1},
        '{1'b0, 1'b0, 1'b0, 3'd0, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pfail = 1'b0, calr = 1'b0, cald = 1'b0;
    logic [MW-1:0] mode = '0;
    logic [7:0]    status = 8'h00;
    logic [PW-1:0] payload = '0;
    logic          data_ready, byte_strobe;
    logic [7:0]    byte_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    meter_pkg_tx #(.PERIOD(P), .MODE_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .pfail_in(pfail), .cal_req_in(calr),
        .cal_done_in(cald), .mode_pins(mode), .status_bus(status),
        .payload_in(payload), .data_ready(data_ready),
        .byte_strobe(byte_strobe), .byte_data(byte_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pay(int v, int k);
        return 8'((v * 16 + k * 3 + 1) & 255);
    endfunction

    function automatic string tag_for(logic [2:0] c, int v);
        if (v == 2)                  return "R10";
        if (c == 3'd7 || v == 3 || v == 4) return "R8";
        if (c == 3'd6 || v == 8)     return "R9";
        return "R7";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise(output int rc, output bit ok);
        int n = 0;
        while (!data_ready && n < 4 * P) begin
            @(negedge clk);
            n++;
        end
        ok = data_ready;
        rc = cyc;
    endtask

    task automatic capture(int v);
        int st [16];
        logic [7:0] sb [16];
        int nb = 0, hi = 0, quiet_bad = 0, fall_ok;
        int exp_t;
        for (int t = 0; t <= 210; t++) begin
            if (t > 0) @(negedge clk);
            if (data_ready) hi++;
            if (byte_strobe) begin
                if (nb < 16) begin
                    st[nb] = t;
                    sb[nb] = byte_data;
                end
                nb++;
            end else if (byte_data != 8'h00) begin
                quiet_bad++;
            end
        end
        fall_ok = data_ready ? 0 : 1;
        check("R2", "ready high cycles", hi, 210);
        check("R2", "ready low at offset 210", fall_ok, 1);
        check("R2", "strobe count", nb, 16);
        check("R6", "data outside strobes", quiet_bad, 0);
        if (nb == 16) begin
            exp_t = 11;
            check("R2", "first strobe offset", st[0], 11);
            for (int k = 1; k < 16; k++) begin
                exp_t = exp_t + (((k - 1) % 2 == 0) ? 12 : 13);
                check("R3", $sformatf("strobe %0d offset", k), st[k], exp_t);
            end
            check("R3", "tail after last byte", 210 - st[15], 12);
            check("R4", "sync high byte", int'(sb[0]), 8'h80);
            check(tag_for(VECS[v].code, v), "code byte (R4)", int'(sb[1]), int'(VECS[v].code));
            check("R5", "mode byte", int'(sb[2]), int'(mode));
            check("R5", "status byte", int'(sb[3]), int'(status));
            for (int k = 4; k < 16; k++) begin
                check("R6", $sformatf("payload byte %0d", k), int'(sb[k]),
                      (VECS[v].code >= 3'd6) ? 0 : int'(pay(v, k - 4)));
            end
        end
    endtask

    initial begin
        int prev_rise = 0, rise = 0, done_cyc = 0, hi_cnt;
        bit ok;
        repeat (4) @(negedge clk);
        check("R1", "ready in reset", int'(data_ready), 0);
        check("R1", "strobe in reset", int'(byte_strobe), 0);
        check("R1", "data in reset", int'(byte_data), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pfail  = VECS[i].pf;
            calr   = VECS[i].cr;
            mode   = MW'(i % 8);
            status = 8'(8'hA0 + i);
            for (int k = 0; k < 12; k++) payload[k * 8 +: 8] = pay(i, k);
            if (i > 0 && VECS[i - 1].done) begin
                hi_cnt = 0;
                for (int n = 0; n < 2 * P; n++) begin
                    @(negedge clk);
                    if (data_ready) hi_cnt++;
                end
                check("R9", "silent while waiting", hi_cnt, 0);
                cald = 1'b1;
                done_cyc = cyc;
                @(negedge clk);
                cald = 1'b0;
            end
            wait_rise(rise, ok);
            check(tag_for(VECS[i].code, i), $sformatf("vector %0d started", i), int'(ok), 1);
            if (!ok) break;
            pfail = 1'b0;
            calr  = VECS[i].done ? calr : 1'b0;
            case (VECS[i].gap)
                2'd1: check(tag_for(VECS[i].code, i), "period between starts", rise - prev_rise, P);
                2'd2: check("R8", "chained start spacing", rise - prev_rise, 211);
                2'd3: check("R9", "start after done", rise - done_cyc, 1);
                default: ;
            endcase
            prev_rise = rise;
            capture(i);
        end

        calr = 1'b0;
        wait_rise(rise, ok);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "ready after mid-package reset", int'(data_ready), 0);
        check("R1", "strobe after mid-package reset", int'(byte_strobe), 0);
        check("R1", "data after mid-package reset", int'(byte_data), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule